// File: doc/BRIEF.md
# I2C Transaction Sequencer

The sequencer sits above a bit-level I2C engine and turns a small set of programmed registers into a sequence of byte commands: opening conditions, the address byte, data bytes in either direction, repeated starts and closing stops. It runs three kinds of transfer: write-only, read-only, and a combined write-then-read that turns the bus around with a repeated start. A transfer can repeat one transaction several times back to back. Consecutive transactions are joined either by a stop followed by a fresh start, or by a repeated start. A launch can also leave the bus held for the next launch.

Write data arrives on a valid/ready byte stream, and read data leaves on another. Either stream can stall the sequencer without losing a byte. Commands go to the bit engine on a valid/ready channel. The engine answers each command once on a response channel that carries the target's acknowledge, a lost-arbitration indication and the received byte. Outcomes are posted as sticky status bits, cleared by writing ones, and a mask selects which status bits drive the interrupt line.

Top module: `i2cseq_top`

## Requirements
- R1: After reset `busy`, `irq`, `cmd_valid`, `tx_ready` and `rx_valid` are low and the status register (index 6) reads 0.
- R2: A write-only launch (target bit 7 clear, control 0) issues the following commands, with op codes START=1, RESTART=2, STOP=3, WRITE=4, READ=5:
  - START;
  - WRITE of the address byte {addr[6:0], 0};
  - WRITE of each of the length-register low-byte data bytes, taken from the tx stream in arrival order;
  - STOP.
- R3: A read-only launch (target bit 7 set) sends the address byte {addr, 1}. It then issues one READ per byte, with `cmd_nack` 0 on every byte except the last, where it is 1. The received bytes leave on the rx stream in order.
- R4: A combined launch needs control bit 0 (repeated start) and bit 1 (direction change) both set. It writes length[7:0] bytes, issues RESTART and the address with the read bit set, and then reads the read length before STOP. The read length is length[15:8], or the auxiliary register (index 2) when parameter AUX_LEN is 1. The count register is not used in this mode.
- R5: With control bit 0 clear, the count register (index 3) runs that many identical transactions, each closed by STOP and each opened by START. A count of 0 runs one transaction.
- R6: With control bit 0 set, chained transactions are joined by RESTART, and only one STOP follows the last transaction.
- R7: If the target does not acknowledge an address or data byte, the sequencer sets status bit 1 and then issues STOP. It sets status bit 0 in a later cycle than bit 1.
- R8: A response that reports lost arbitration sets status bits 3 and 0, and no further command is issued.
- R9: Busy behaviour:
  - a write to the start register (index 5) with bit 0 set raises `busy`, which stays high until status bit 0 is posted;
  - start writes while `busy` is high are ignored;
  - a start write with bit 0 clear launches nothing.
- R10: Start bit 14 sets status bit 4 at the end of every transaction. Start bit 15 replaces the final STOP with holding the bus, and the next launch then opens with RESTART instead of START.
- R11: Status bits are: 0 complete, 1 ACK error, 2 high-speed NACK (never set here), 3 arbitration lost, 4 restart done. Writing a 1 to a status bit clears it, and a new event in the same cycle wins. `irq` is the OR of the status bits gated by the mask register (index 7).
- R12: Stream rules:
  - `cmd_valid` with its op, data and NACK flag holds steady until `cmd_ready`;
  - `rx_valid` and `rx_data` hold until `rx_ready`;
  - a tx byte is consumed only on `tx_valid && tx_ready`;
  - any stall delays the sequence without altering it.
- R13: Register indices:
  - 0: target, with bits 6:0 the address and bit 7 the read flag;
  - 1: length;
  - 2: auxiliary read length;
  - 3: count;
  - 4: control;
  - 5: start;
  - 6: status;
  - 7: mask.
  
  Configuration is captured at launch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the indexed register |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Masked interrupt |
| cmd_valid | output | 1 | Command to bit engine valid |
| cmd_ready | input | 1 | Bit engine accepts command |
| cmd_op | output | 3 | Command op code |
| cmd_wdata | output | 8 | Byte to send for WRITE |
| cmd_nack | output | 1 | Send NACK after this READ byte |
| rsp_valid | input | 1 | Command response valid |
| rsp_ready | output | 1 | Sequencer takes the response |
| rsp_ack | input | 1 | Target acknowledged the written byte |
| rsp_lost | input | 1 | Arbitration lost during command |
| rsp_data | input | 8 | Byte received by READ |
| tx_valid | input | 1 | Write byte available |
| tx_ready | output | 1 | Sequencer takes write byte |
| tx_data | input | 8 | Write byte |
| rx_valid | output | 1 | Read byte available |
| rx_ready | input | 1 | Consumer takes read byte |
| rx_data | output | 8 | Read byte |

## Verification
The assertions assume a bit engine that returns exactly one response per accepted command and raises `rsp_valid` only while a command is outstanding. They also assume that `tx_valid`, once offered, is not withdrawn. The bench's responder records each command at its handshake and answers two cycles later, holding the response until `rsp_ready`. Its tx source keeps `tx_valid` high at all times. Back-pressure is applied by toggling `cmd_ready` and `rx_ready` from a free-running counter, so stalls never depend on the sequencer's own outputs.

// File: rtl/i2cseq_pkg.sv
`timescale 1ns/1ps
package i2cseq_pkg;
  localparam int BYTE_W = 8;
  localparam int NSTAT  = 5;
  localparam int REG_AW = 4;
  localparam int REG_DW = 16;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_START   = 3'd1,
    OP_RESTART = 3'd2,
    OP_STOP    = 3'd3,
    OP_WRITE   = 3'd4,
    OP_READ    = 3'd5
  } cmd_op_e;

  localparam logic [REG_AW-1:0] RA_TARGET = REG_AW'(0);
  localparam logic [REG_AW-1:0] RA_LEN    = REG_AW'(1);
  localparam logic [REG_AW-1:0] RA_AUX    = REG_AW'(2);
  localparam logic [REG_AW-1:0] RA_COUNT  = REG_AW'(3);
  localparam logic [REG_AW-1:0] RA_CTRL   = REG_AW'(4);
  localparam logic [REG_AW-1:0] RA_START  = REG_AW'(5);
  localparam logic [REG_AW-1:0] RA_STATUS = REG_AW'(6);
  localparam logic [REG_AW-1:0] RA_MASK   = REG_AW'(7);

  // status bit positions
  localparam int ST_DONE   = 0;
  localparam int ST_ACKERR = 1;
  localparam int ST_HSNACK = 2;
  localparam int ST_ARB    = 3;
  localparam int ST_RSDONE = 4;

  // start and control bit positions
  localparam int SB_GO    = 0;
  localparam int SB_MULTI = 14;
  localparam int SB_HOLD  = 15;
  localparam int CB_RS    = 0;
  localparam int CB_DIR   = 1;

  typedef struct packed {
    logic [6:0]        addr;
    logic              rd;
    logic [BYTE_W-1:0] wr_len;
    logic [BYTE_W-1:0] rd_len;
    logic [BYTE_W-1:0] count;
    logic              rs;
    logic              dir;
  } cfg_t;
endpackage

// File: rtl/i2cseq_regs.sv
`timescale 1ns/1ps
module i2cseq_regs
  import i2cseq_pkg::*;
#(
  parameter bit AUX_LEN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic              busy,
  input  logic [NSTAT-1:0]  status,
  output logic [REG_DW-1:0] reg_rdata,
  output cfg_t              cfg,
  output logic              go,
  output logic              multi,
  output logic              hold,
  output logic [NSTAT-1:0]  clr,
  output logic [NSTAT-1:0]  mask
);
  logic [BYTE_W-1:0] target_q;
  logic [REG_DW-1:0] len_q;
  logic [BYTE_W-1:0] count_q;
  logic [1:0]        ctrl_q;
  logic [NSTAT-1:0]  mask_q;
  logic [BYTE_W-1:0] rd_len;
  logic [REG_DW-1:0] aux_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      len_q    <= '0;
      count_q  <= '0;
      ctrl_q   <= '0;
      mask_q   <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        RA_TARGET: target_q <= reg_wdata[BYTE_W-1:0];
        RA_LEN:    len_q    <= reg_wdata;
        RA_COUNT:  count_q  <= reg_wdata[BYTE_W-1:0];
        RA_CTRL:   ctrl_q   <= reg_wdata[1:0];
        RA_MASK:   mask_q   <= reg_wdata[NSTAT-1:0];
        default: ;
      endcase
    end
  end

  // Read length source picked by parameter
  generate
    if (AUX_LEN) begin : g_aux
      logic [BYTE_W-1:0] aux_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          aux_q <= '0;
        else if (reg_we && reg_addr == RA_AUX) aux_q <= reg_wdata[BYTE_W-1:0];
      end
      assign rd_len   = aux_q;
      assign aux_view = REG_DW'(aux_q);
    end else begin : g_packed
      assign rd_len   = len_q[REG_DW-1:BYTE_W];
      assign aux_view = '0;
    end
  endgenerate

  assign cfg.addr   = target_q[6:0];
  assign cfg.rd     = target_q[7];
  assign cfg.wr_len = len_q[BYTE_W-1:0];
  assign cfg.rd_len = rd_len;
  assign cfg.count  = count_q;
  assign cfg.rs     = ctrl_q[CB_RS];
  assign cfg.dir    = ctrl_q[CB_DIR];

  assign go    = reg_we && (reg_addr == RA_START) && reg_wdata[SB_GO] && !busy;
  assign multi = reg_wdata[SB_MULTI];
  assign hold  = reg_wdata[SB_HOLD];
  assign clr   = (reg_we && reg_addr == RA_STATUS) ? reg_wdata[NSTAT-1:0] : '0;
  assign mask  = mask_q;

  always_comb begin
    case (reg_addr)
      RA_TARGET: reg_rdata = REG_DW'(target_q);
      RA_LEN:    reg_rdata = len_q;
      RA_AUX:    reg_rdata = aux_view;
      RA_COUNT:  reg_rdata = REG_DW'(count_q);
      RA_CTRL:   reg_rdata = REG_DW'(ctrl_q);
      RA_STATUS: reg_rdata = REG_DW'(status);
      RA_MASK:   reg_rdata = REG_DW'(mask_q);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2cseq_status.sv
`timescale 1ns/1ps
module i2cseq_status #(
  parameter int NB = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set,
  input  logic [NB-1:0] clr,
  input  logic [NB-1:0] mask,
  output logic [NB-1:0] status,
  output logic          irq
);
  generate
    for (genvar i = 0; i < NB; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      status[i] <= 1'b0;
        else if (set[i]) status[i] <= 1'b1;
        else if (clr[i]) status[i] <= 1'b0;
      end

      // R11: an event beats a same-cycle clear
      a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set[i] |=> status[i]);
      // R11: a one written without an event clears the bit
      a_r11_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && !set[i]) |=> !status[i]);
    end
  endgenerate

  assign irq = |(status & mask);
endmodule

// File: rtl/i2cseq_fsm.sv
`timescale 1ns/1ps
module i2cseq_fsm
  import i2cseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              multi,
  input  logic              hold,
  input  cfg_t              cfg,
  output logic              busy,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_op,
  output logic [BYTE_W-1:0] cmd_wdata,
  output logic              cmd_nack,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic              rsp_ack,
  input  logic              rsp_lost,
  input  logic [BYTE_W-1:0] rsp_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic [NSTAT-1:0]  ev
);
  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_RSP, S_TXWAIT, S_RXPUSH, S_END, S_DONE
  } state_e;

  state_e            state;
  cmd_op_e           cur_op;
  logic [BYTE_W-1:0] cur_byte;
  logic              cur_nack;
  logic              is_addr;
  logic              phase_rd;
  logic [BYTE_W-1:0] byte_cnt;
  logic [BYTE_W-1:0] txn_left;
  cfg_t              cfg_q;
  logic              multi_q;
  logic              hold_q;
  logic              held;
  logic              more_after_stop;
  logic              aborting;
  logic [BYTE_W-1:0] rx_q;

  logic              comb;
  logic              cur_rd;
  logic [BYTE_W-1:0] cur_len;
  logic              last_byte;

  assign comb      = cfg_q.dir && cfg_q.rs;
  assign cur_rd    = comb ? phase_rd : cfg_q.rd;
  assign cur_len   = (comb && phase_rd) ? cfg_q.rd_len : cfg_q.wr_len;
  assign last_byte = (byte_cnt + BYTE_W'(1)) == cur_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state           <= S_IDLE;
      cur_op          <= OP_NONE;
      cur_byte        <= '0;
      cur_nack        <= 1'b0;
      is_addr         <= 1'b0;
      phase_rd        <= 1'b0;
      byte_cnt        <= '0;
      txn_left        <= '0;
      cfg_q           <= '0;
      multi_q         <= 1'b0;
      hold_q          <= 1'b0;
      held            <= 1'b0;
      more_after_stop <= 1'b0;
      aborting        <= 1'b0;
      rx_q            <= '0;
      busy            <= 1'b0;
      ev              <= '0;
    end else begin
      ev <= '0;
      case (state)
        S_IDLE: begin
          if (go) begin
            cfg_q           <= cfg;
            multi_q         <= multi;
            hold_q          <= hold;
            busy            <= 1'b1;
            byte_cnt        <= '0;
            phase_rd        <= 1'b0;
            aborting        <= 1'b0;
            more_after_stop <= 1'b0;
            txn_left        <= (cfg.count == '0) ? BYTE_W'(1) : cfg.count;
            cur_op          <= held ? OP_RESTART : OP_START;
            state           <= S_CMD;
          end
        end
        S_CMD: begin
          if (cmd_ready) state <= S_RSP;
        end
        S_RSP: begin
          if (rsp_valid) begin
            if (rsp_lost) begin
              ev[ST_ARB] <= 1'b1;
              held       <= 1'b0;
              state      <= S_DONE;
            end else begin
              case (cur_op)
                OP_START, OP_RESTART: begin
                  held     <= 1'b0;
                  cur_op   <= OP_WRITE;
                  cur_byte <= {cfg_q.addr, cur_rd};
                  is_addr  <= 1'b1;
                  byte_cnt <= '0;
                  state    <= S_CMD;
                end
                OP_WRITE: begin
                  if (!rsp_ack) begin
                    ev[ST_ACKERR] <= 1'b1;
                    aborting      <= 1'b1;
                    cur_op        <= OP_STOP;
                    state         <= S_CMD;
                  end else if (is_addr) begin
                    is_addr <= 1'b0;
                    if (cur_len == '0) begin
                      state <= S_END;
                    end else if (cur_rd) begin
                      cur_op   <= OP_READ;
                      cur_nack <= (cur_len == BYTE_W'(1));
                      state    <= S_CMD;
                    end else begin
                      state <= S_TXWAIT;
                    end
                  end else if (last_byte) begin
                    state <= S_END;
                  end else begin
                    byte_cnt <= byte_cnt + BYTE_W'(1);
                    state    <= S_TXWAIT;
                  end
                end
                OP_READ: begin
                  rx_q  <= rsp_data;
                  state <= S_RXPUSH;
                end
                default: begin
                  if (!aborting && more_after_stop) begin
                    more_after_stop <= 1'b0;
                    cur_op          <= OP_START;
                    state           <= S_CMD;
                  end else begin
                    state <= S_DONE;
                  end
                end
              endcase
            end
          end
        end
        S_TXWAIT: begin
          if (tx_valid) begin
            cur_byte <= tx_data;
            cur_op   <= OP_WRITE;
            state    <= S_CMD;
          end
        end
        S_RXPUSH: begin
          if (rx_ready) begin
            if (last_byte) begin
              state <= S_END;
            end else begin
              byte_cnt <= byte_cnt + BYTE_W'(1);
              cur_op   <= OP_READ;
              cur_nack <= (byte_cnt + BYTE_W'(2)) == cur_len;
              state    <= S_CMD;
            end
          end
        end
        S_END: begin
          if (multi_q) ev[ST_RSDONE] <= 1'b1;
          byte_cnt <= '0;
          state    <= S_CMD;
          if (comb && !phase_rd) begin
            phase_rd <= 1'b1;
            cur_op   <= OP_RESTART;
          end else if (!comb && txn_left > BYTE_W'(1)) begin
            txn_left <= txn_left - BYTE_W'(1);
            if (cfg_q.rs) begin
              cur_op <= OP_RESTART;
            end else begin
              cur_op          <= OP_STOP;
              more_after_stop <= 1'b1;
            end
          end else if (hold_q) begin
            held  <= 1'b1;
            state <= S_DONE;
          end else begin
            cur_op          <= OP_STOP;
            more_after_stop <= 1'b0;
          end
        end
        S_DONE: begin
          ev[ST_DONE] <= 1'b1;
          busy        <= 1'b0;
          state       <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_valid = (state == S_CMD);
  assign cmd_op    = cur_op;
  assign cmd_wdata = cur_byte;
  assign cmd_nack  = cur_nack;
  assign rsp_ready = (state == S_RSP);
  assign tx_ready  = (state == S_TXWAIT);
  assign rx_valid  = (state == S_RXPUSH);
  assign rx_data   = rx_q;

  // R12: a stalled command stays put
  a_r12_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_wdata) && $stable(cmd_nack)));
  // R12: a stalled read byte stays put
  a_r12_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  // R7: completion is never posted with or right after the ACK error
  a_r7_err_first: assert property (@(posedge clk) disable iff (!rst_n)
    ev[ST_ACKERR] |=> !ev[ST_DONE]);
  // R9: busy only drops together with the completion event
  a_r9_busy_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ev[ST_DONE]);
  // R8: nothing is commanded once arbitration is lost
  a_r8_arb_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ev[ST_ARB] |-> !cmd_valid);
endmodule

// File: rtl/i2cseq_top.sv
`timescale 1ns/1ps
module i2cseq_top
  import i2cseq_pkg::*;
#(
  parameter bit AUX_LEN = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        busy,
  output logic        irq,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [2:0]  cmd_op,
  output logic [7:0]  cmd_wdata,
  output logic        cmd_nack,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic        rsp_ack,
  input  logic        rsp_lost,
  input  logic [7:0]  rsp_data,
  input  logic        tx_valid,
  output logic        tx_ready,
  input  logic [7:0]  tx_data,
  output logic        rx_valid,
  input  logic        rx_ready,
  output logic [7:0]  rx_data
);
  cfg_t             cfg;
  logic             go, multi, hold;
  logic [NSTAT-1:0] clr, mask, status, ev;

  i2cseq_regs #(.AUX_LEN(AUX_LEN)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .status(status), .reg_rdata(reg_rdata),
    .cfg(cfg), .go(go), .multi(multi), .hold(hold), .clr(clr), .mask(mask)
  );

  i2cseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .go(go), .multi(multi), .hold(hold), .cfg(cfg),
    .busy(busy), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .cmd_nack(cmd_nack), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_ack(rsp_ack), .rsp_lost(rsp_lost),
    .rsp_data(rsp_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .ev(ev)
  );

  i2cseq_status #(.NB(NSTAT)) u_status (
    .clk(clk), .rst_n(rst_n), .set(ev), .clr(clr), .mask(mask),
    .status(status), .irq(irq)
  );
endmodule

// File: tb/sim_i2cseq_top.sv
`timescale 1ns/1ps
module sim_i2cseq_top;
  localparam logic [6:0] TGT = 7'h50;
  localparam int OP_ST = 1, OP_RS = 2, OP_SP = 3, OP_WR = 4, OP_RD = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'd6;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        busy, irq, cmd_valid, cmd_ready, cmd_nack, rsp_ready;
  logic [2:0]  cmd_op;
  logic [7:0]  cmd_wdata;
  logic        rsp_valid = 1'b0, rsp_ack = 1'b0, rsp_lost = 1'b0;
  logic [7:0]  rsp_data = '0;
  logic        tx_valid, tx_ready, rx_valid, rx_ready;
  logic [7:0]  tx_data, rx_data;

  always #2 clk = ~clk;   // 4 ns period

  i2cseq_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .irq(irq),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .cmd_nack(cmd_nack), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_ack(rsp_ack), .rsp_lost(rsp_lost),
    .rsp_data(rsp_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data)
  );

  // ---------------- responder model ----------------
  int         log_n = 0, rx_n = 0, tx_idx = 0, rd_ctr = 0;
  logic [2:0] log_op [0:1023];
  logic [7:0] log_dat[0:1023];
  logic       log_nk [0:1023];
  logic [7:0] rx_log [0:1023];
  logic [7:0] cyc = '0;
  logic [2:0] pend_op = '0;
  logic [7:0] pend_dat = '0;
  int         dly = 0;
  logic       expect_addr = 1'b0;
  logic       stall_en = 1'b0;
  logic       lose_arm = 1'b0;

  function automatic logic [7:0] txpat(input int i);
    return 8'(i * 29 + 17);
  endfunction

  assign cmd_ready = !stall_en || cyc[1];
  assign rx_ready  = !stall_en || cyc[0];
  assign tx_valid  = 1'b1;
  assign tx_data   = txpat(tx_idx);

  always @(posedge clk) begin
    cyc <= cyc + 8'd1;
    if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
    if (cmd_valid && cmd_ready) begin
      log_op[log_n]  <= cmd_op;
      log_dat[log_n] <= (cmd_op == 3'(OP_WR)) ? cmd_wdata : 8'h00;
      log_nk[log_n]  <= (cmd_op == 3'(OP_RD)) ? cmd_nack : 1'b0;
      log_n    <= log_n + 1;
      pend_op  <= cmd_op;
      pend_dat <= cmd_wdata;
      dly      <= 2;
      if (cmd_op == 3'(OP_ST) || cmd_op == 3'(OP_RS)) expect_addr <= 1'b1;
    end
    if (dly != 0) begin
      dly <= dly - 1;
      if (dly == 1) begin
        rsp_valid <= 1'b1;
        rsp_ack   <= 1'b1;
        rsp_lost  <= 1'b0;
        if (pend_op == 3'(OP_WR)) begin
          rsp_lost <= lose_arm;
          if (expect_addr) begin
            rsp_ack     <= (pend_dat[7:1] == TGT);
            expect_addr <= 1'b0;
          end
        end
        if (pend_op == 3'(OP_RD)) begin
          rsp_data <= 8'(8'hA0 + rd_ctr);
          rd_ctr   <= rd_ctr + 1;
        end
      end
    end
    if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;
    if (rx_valid && rx_ready) begin
      rx_log[rx_n] <= rx_data;
      rx_n <= rx_n + 1;
    end
  end

  // ---------------- checking helpers ----------------
  int checks = 0, fails = 0;
  int exp_n = 0;
  int exp_op[0:63];
  int exp_val[0:63];
  int log_base, tx_base, rd_base, rx_base;
  int t_err, t_done;

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic mark();
    log_base = log_n; tx_base = tx_idx; rd_base = rd_ctr; rx_base = rx_n; exp_n = 0;
  endtask

  task automatic push(input int op, input int val);
    exp_op[exp_n] = op; exp_val[exp_n] = val; exp_n++;
  endtask

  task automatic cmp_log(input string req);
    chk({req, " command count"}, log_n - log_base, exp_n);
    for (int k = 0; k < exp_n; k++) begin
      if (log_n - log_base > k) begin
        chk({req, " op"}, int'(log_op[log_base + k]), exp_op[k]);
        if (exp_op[k] == OP_WR) chk({req, " byte"}, int'(log_dat[log_base + k]), exp_val[k]);
        if (exp_op[k] == OP_RD) chk({req, " nack"}, int'(log_nk[log_base + k]), exp_val[k]);
      end
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 4'd6;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 4'd6;
  endtask

  task automatic wait_idle(input string req);
    int n;
    n = 0; t_err = -1; t_done = -1;
    reg_addr = 4'd6;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
      if (reg_rdata[1] && t_err < 0)  t_err = n;
      if (reg_rdata[0] && t_done < 0) t_done = n;
    end
    chk({req, " finished"}, int'(busy), 0);
    repeat (2) begin
      @(negedge clk);
      n++;
      if (reg_rdata[1] && t_err < 0)  t_err = n;
      if (reg_rdata[0] && t_done < 0) t_done = n;
    end
  endtask

  task automatic setup(input logic [7:0] tgt, input logic [15:0] len,
                       input logic [7:0] cnt, input logic [1:0] ctl);
    wr(4'd6, 16'h001F);
    wr(4'd0, {8'h00, tgt});
    wr(4'd1, len);
    wr(4'd3, {8'h00, cnt});
    wr(4'd4, {14'h0, ctl});
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [15:0] s;
    chk("R1 busy", int'(busy), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 cmd_valid", int'(cmd_valid), 0);
    chk("R1 tx_ready", int'(tx_ready), 0);
    chk("R1 rx_valid", int'(rx_valid), 0);
    rd(4'd6, s);
    chk("R1 status", int'(s), 0);
  endtask

  task automatic t_write();
    logic [15:0] s;
    setup({1'b0, TGT}, 16'h0003, 8'd1, 2'b00);
    wr(4'd7, 16'h0001);
    mark();
    wr(4'd5, 16'h0001);
    wait_idle("R2");
    push(OP_ST, 0); push(OP_WR, {TGT, 1'b0});
    for (int k = 0; k < 3; k++) push(OP_WR, int'(txpat(tx_base + k)));
    push(OP_SP, 0);
    cmp_log("R2 write");
    rd(4'd6, s);
    chk("R11 status after write", int'(s), 1);
    chk("R11 irq masked on", int'(irq), 1);
    wr(4'd6, 16'h0001);
    rd(4'd6, s);
    chk("R11 status cleared", int'(s), 0);
    chk("R11 irq off", int'(irq), 0);
    rd(4'd1, s);
    chk("R13 length readback", int'(s), 3);
  endtask

  task automatic t_read();
    logic [15:0] s;
    setup({1'b1, TGT}, 16'h0003, 8'd0, 2'b00);
    wr(4'd7, 16'h0000);
    stall_en = 1'b1;
    mark();
    wr(4'd5, 16'h0001);
    wait_idle("R3");
    stall_en = 1'b0;
    push(OP_ST, 0); push(OP_WR, {TGT, 1'b1});
    push(OP_RD, 0); push(OP_RD, 0); push(OP_RD, 1); push(OP_SP, 0);
    cmp_log("R3 R5 R12 read count0");
    chk("R3 rx count", rx_n - rx_base, 3);
    for (int k = 0; k < 3; k++)
      chk("R3 R12 rx byte", int'(rx_log[rx_base + k]), int'(8'(8'hA0 + rd_base + k)));
    rd(4'd6, s);
    chk("R11 status mask0", int'(s), 1);
    chk("R11 irq mask0", int'(irq), 0);
  endtask

  task automatic t_combined();
    setup({1'b0, TGT}, 16'h0201, 8'd2, 2'b11);
    stall_en = 1'b1;
    mark();
    wr(4'd5, 16'h0001);
    wait_idle("R4");
    stall_en = 1'b0;
    push(OP_ST, 0); push(OP_WR, {TGT, 1'b0}); push(OP_WR, int'(txpat(tx_base)));
    push(OP_RS, 0); push(OP_WR, {TGT, 1'b1});
    push(OP_RD, 0); push(OP_RD, 1); push(OP_SP, 0);
    cmp_log("R4 combined");
    chk("R4 rx byte0", int'(rx_log[rx_base]), int'(8'(8'hA0 + rd_base)));
    chk("R4 rx byte1", int'(rx_log[rx_base + 1]), int'(8'(8'hA1 + rd_base)));
  endtask

  task automatic t_chain(input logic rs);
    logic [15:0] s;
    setup({1'b0, TGT}, 16'h0001, 8'd2, {1'b0, rs});
    mark();
    wr(4'd5, rs ? 16'h4001 : 16'h0001);
    wait_idle(rs ? "R6" : "R5");
    push(OP_ST, 0); push(OP_WR, {TGT, 1'b0}); push(OP_WR, int'(txpat(tx_base)));
    if (rs) push(OP_RS, 0);
    else begin push(OP_SP, 0); push(OP_ST, 0); end
    push(OP_WR, {TGT, 1'b0}); push(OP_WR, int'(txpat(tx_base + 1))); push(OP_SP, 0);
    cmp_log(rs ? "R6 chain restart" : "R5 chain stop");
    rd(4'd6, s);
    chk(rs ? "R10 status multi" : "R5 status", int'(s), rs ? 32'h11 : 32'h01);
  endtask

  task automatic t_nack();
    logic [15:0] s;
    setup({1'b0, 7'h33}, 16'h0002, 8'd1, 2'b00);
    mark();
    wr(4'd5, 16'h0001);
    wait_idle("R7");
    push(OP_ST, 0); push(OP_WR, {7'h33, 1'b0}); push(OP_SP, 0);
    cmp_log("R7 nack");
    rd(4'd6, s);
    chk("R7 status", int'(s), 3);
    chk("R7 error before done", int'(t_err >= 0 && t_done > t_err), 1);
  endtask

  task automatic t_busy();
    int snap;
    setup({1'b0, TGT}, 16'h0002, 8'd1, 2'b00);
    mark();
    wr(4'd5, 16'h0001);
    chk("R9 busy after launch", int'(busy), 1);
    wr(4'd5, 16'h0001);
    wait_idle("R9");
    push(OP_ST, 0); push(OP_WR, {TGT, 1'b0});
    push(OP_WR, int'(txpat(tx_base))); push(OP_WR, int'(txpat(tx_base + 1))); push(OP_SP, 0);
    repeat (10) @(negedge clk);
    cmp_log("R9 start while busy");
    snap = log_n;
    wr(4'd5, 16'h4000);
    chk("R9 no launch bit0 clear", int'(busy), 0);
    repeat (10) @(negedge clk);
    chk("R9 no commands", log_n - snap, 0);
  endtask

  task automatic t_hold();
    logic [15:0] s;
    setup({1'b0, TGT}, 16'h0001, 8'd1, 2'b00);
    mark();
    wr(4'd5, 16'hC001);
    wait_idle("R10");
    push(OP_ST, 0); push(OP_WR, {TGT, 1'b0}); push(OP_WR, int'(txpat(tx_base)));
    cmp_log("R10 hold no stop");
    rd(4'd6, s);
    chk("R10 status hold", int'(s), 32'h11);
    wr(4'd6, 16'h001F);
    mark();
    wr(4'd5, 16'h0001);
    wait_idle("R10");
    push(OP_RS, 0); push(OP_WR, {TGT, 1'b0}); push(OP_WR, int'(txpat(tx_base))); push(OP_SP, 0);
    cmp_log("R10 reopen restart");
    rd(4'd6, s);
    chk("R10 status reopen", int'(s), 1);
  endtask

  task automatic t_arb();
    logic [15:0] s;
    setup({1'b0, TGT}, 16'h0001, 8'd1, 2'b00);
    lose_arm = 1'b1;
    mark();
    wr(4'd5, 16'h0001);
    wait_idle("R8");
    lose_arm = 1'b0;
    repeat (6) @(negedge clk);
    push(OP_ST, 0); push(OP_WR, {TGT, 1'b0});
    cmp_log("R8 arb lost");
    rd(4'd6, s);
    chk("R8 status", int'(s), 32'h09);
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_combined();
    t_chain(1'b0);
    t_chain(1'b1);
    t_nack();
    t_busy();
    t_hold();
    t_arb();
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
    $finish;
  end
endmodule